// File: doc/BRIEF.md
# IIR Filter Sequencing Engine

This block runs a direct-form IIR filter out of local storage. It has three stores. The first is a coefficient bank that holds the feed-forward taps followed directly by the feedback taps. The second is an input sample ring, filled from a valid/ready stream. The third is an output ring. The output ring has two roles: it is the filter's feedback delay line, and it is the queue that a valid/ready output stream drains.

Software loads the coefficients. It may also preload feedback history while the engine is idle. A single parameter write then starts the engine. That write carries a function code, the feed-forward count, the feedback count, a gain shift and a start bit.

For each output, the engine accumulates P products over input samples and Q products over history entries, one product per cycle. It scales the sum and writes the result into the output ring. It then slides both windows by one. A later parameter write with the start bit clear stops it.

Back-pressure works as follows:
- `x_ready` drops when the input ring is full. A sample transfers on any cycle where `x_valid` and `x_ready` are both high.
- `y_valid` stays high, with `y_data` unchanged, until `y_ready` takes the word.
- When the output ring holds a full ring of unread results, the engine waits and does not overwrite them.

Top module: `iir_seq_engine`

## Requirements
- R1: After reset, `busy` is 0, `y_valid` is 0 and `x_ready` is 1.
- R2: A parameter write starts the engine only if all of these hold: the engine is idle, `param_start` is 1, `param_func` equals 9, `param_p` is between 1 and MAX_P, and `param_q` is at most MAX_Q. Any other write with the start bit set leaves `busy` at 0.
- R3: Coefficient address i for i < P is the feed-forward tap applied to input window sample i. Address P+j is the feedback tap applied to history entry j.
- R4: Each output is sat((Σ c[i]·x[i] + Σ c[P+j]·h[j]) <<< R). Here x[0] is the oldest unconsumed input sample, and h[j] is output-ring entry (fb + j) mod YDEPTH.
- R5: After a start, fb is 0. The first result goes to output-ring address Q. Entries 0..Q−1, as preloaded through the history port or left by earlier use, form the first feedback window.
- R6: No output is computed while the input ring holds fewer than P samples.
- R7: After each output, the oldest input sample is consumed and fb advances by one. Later outputs therefore use earlier results as feedback.
- R8: The shifted sum saturates to the signed output width: above 32767 gives 32767, and below −32768 gives −32768.
- R9: While YDEPTH results are unread, the engine stalls. It consumes no input and loses no result.
- R10: `x_ready` is 1 exactly when the input ring holds fewer than XDEPTH samples.
- R11: A parameter write with `param_start` = 0 returns `busy` to 0 on the next cycle. No further results appear after that.
- R12: With P samples present and a free output slot, `y_valid` rises P+Q+2 clock edges after the edge that captures the start write.
- R13: While `y_valid` is high and `y_ready` is low, `y_valid` stays high and `y_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_we | input | 1 | Parameter write strobe |
| param_func | input | 4 | Function code (9 = IIR) |
| param_p | input | 4 | Feed-forward tap count P |
| param_q | input | 4 | Feedback tap count Q |
| param_gain | input | 3 | Gain shift R |
| param_start | input | 1 | Start (1) or stop (0) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient address |
| coef_data | input | 16 | Signed coefficient |
| hist_we | input | 1 | History preload strobe (honoured only while idle) |
| hist_addr | input | 4 | Output-ring address to preload |
| hist_data | input | 16 | Signed history value |
| x_valid | input | 1 | Input sample valid |
| x_ready | output | 1 | Input ring has room |
| x_data | input | 16 | Signed input sample |
| y_valid | output | 1 | Unread result available |
| y_ready | input | 1 | Consumer takes the result |
| y_data | output | 16 | Signed result |
| busy | output | 1 | Engine running |

## Verification
Each result becomes visible P+Q+2 edges after the conditions that enable it are met. There is one edge to leave the wait state, P+Q edges of accumulation, and one write edge. The bench measures that count at the falling edge for a start with all samples already present, and requires the exact value.

Every other check waits for `y_valid` at a falling edge, compares `y_data` against a reference model built from the requirement formulas, and only then raises `y_ready` for one edge. Stall and stop cases hold the stimulus for tens of cycles, several times the compute time, before they check that no result appeared.

// File: rtl/iir_seq_pkg.sv
package iir_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MAC,
    ST_WRITE
  } eng_state_t;

  localparam logic [3:0] FUNC_IIR = 4'd9;
endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank #(
  parameter int CW  = 16,
  parameter int NUM = 15,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [CW-1:0] tap_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) tap_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) tap_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_addr) < NUM) rd_data = tap_q[rd_addr];
  end
endmodule

// File: rtl/iir_sample_ring.sv
module iir_sample_ring #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  input  logic [AW-1:0] win_off,
  output logic [DW-1:0] win_data,
  output logic [AW:0]   count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [AW:0]   cnt_q;
  logic          push;

  assign in_ready = cnt_q < (AW+1)'(DEPTH);
  assign push     = in_valid && in_ready;
  assign win_data = mem[head_q + win_off];
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[tail_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // the engine only consumes a sample it has already counted in
  assert_pop_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/iir_mac_unit.sv
module iir_mac_unit #(
  parameter int CW   = 16,
  parameter int DW   = 16,
  parameter int ACCW = 40,
  parameter int GW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] operand,
  input  logic [GW-1:0]        gain,
  output logic signed [DW-1:0] result
);
  localparam int SW = ACCW + (1 << GW);
  localparam logic signed [SW-1:0] HI = SW'((1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [ACCW-1:0]  acc_q;
  logic signed [CW+DW-1:0] prod;
  logic signed [SW-1:0]    scaled;

  assign prod   = coef * operand;
  assign scaled = SW'(acc_q) <<< gain;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (en)       acc_q <= acc_q + ACCW'(prod);
  end

  always_comb begin
    if (scaled > HI)      result = HI[DW-1:0];
    else if (scaled < LO) result = LO[DW-1:0];
    else                  result = scaled[DW-1:0];
  end
endmodule

// File: rtl/iir_seq_engine.sv
module iir_seq_engine
  import iir_seq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int ACCW   = 40,
  parameter int MAX_P  = 8,
  parameter int MAX_Q  = 7,
  parameter int XDEPTH = 16,
  parameter int YDEPTH = 16,
  parameter int GW     = 3,
  parameter int CNTW   = 4,
  localparam int CAW   = $clog2(MAX_P + MAX_Q),
  localparam int XAW   = $clog2(XDEPTH),
  localparam int YAW   = $clog2(YDEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            param_we,
  input  logic [3:0]      param_func,
  input  logic [CNTW-1:0] param_p,
  input  logic [CNTW-1:0] param_q,
  input  logic [GW-1:0]   param_gain,
  input  logic            param_start,
  input  logic            coef_we,
  input  logic [CAW-1:0]  coef_addr,
  input  logic [CW-1:0]   coef_data,
  input  logic            hist_we,
  input  logic [YAW-1:0]  hist_addr,
  input  logic [DW-1:0]   hist_data,
  input  logic            x_valid,
  output logic            x_ready,
  input  logic [DW-1:0]   x_data,
  output logic            y_valid,
  input  logic            y_ready,
  output logic [DW-1:0]   y_data,
  output logic            busy
);
  eng_state_t     state_q;
  logic [CNTW-1:0] p_q, q_q;
  logic [GW-1:0]  gain_q;
  logic [CAW:0]   k_q, terms;
  logic [YAW-1:0] fb_q, wr_q, rd_q, fb_idx;
  logic [YAW:0]   unread_q;
  logic [DW-1:0]  y_mem [YDEPTH];
  logic [XAW:0]   x_count;
  logic [DW-1:0]  x_win;
  logic [CW-1:0]  coef_rd;
  logic [DW-1:0]  sat_res;
  logic           start_ok, stop_req, in_ff, y_space, y_pop, do_write;

  assign start_ok = param_we && param_start && param_func == FUNC_IIR &&
                    param_p != '0 && param_p <= CNTW'(MAX_P) &&
                    param_q <= CNTW'(MAX_Q);
  assign stop_req = param_we && !param_start;
  assign terms    = (CAW+1)'(p_q) + (CAW+1)'(q_q);
  assign in_ff    = k_q < (CAW+1)'(p_q);
  assign fb_idx   = fb_q + YAW'(k_q - (CAW+1)'(p_q));
  assign y_space  = unread_q < (YAW+1)'(YDEPTH);
  assign y_valid  = unread_q != '0;
  assign y_data   = y_mem[rd_q];
  assign y_pop    = y_valid && y_ready;
  assign do_write = state_q == ST_WRITE && !stop_req;
  assign busy     = state_q != ST_IDLE;

  iir_coef_bank #(.CW(CW), .NUM(MAX_P + MAX_Q)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
    .wr_data(coef_data), .rd_addr(k_q[CAW-1:0]), .rd_data(coef_rd)
  );

  iir_sample_ring #(.DW(DW), .DEPTH(XDEPTH)) u_xring (
    .clk(clk), .rst_n(rst_n), .in_valid(x_valid), .in_ready(x_ready),
    .in_data(x_data), .pop(do_write), .win_off(XAW'(k_q)),
    .win_data(x_win), .count(x_count)
  );

  iir_mac_unit #(.CW(CW), .DW(DW), .ACCW(ACCW), .GW(GW)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_WAIT),
    .en(state_q == ST_MAC), .coef(coef_rd),
    .operand(in_ff ? x_win : y_mem[fb_idx]), .gain(gain_q), .result(sat_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      p_q      <= '0;
      q_q      <= '0;
      gain_q   <= '0;
      k_q      <= '0;
      fb_q     <= '0;
      wr_q     <= '0;
      rd_q     <= '0;
      unread_q <= '0;
      for (int i = 0; i < YDEPTH; i++) y_mem[i] <= '0;
    end else begin
      if (y_pop) rd_q <= rd_q + 1'b1;
      unread_q <= unread_q + (YAW+1)'(do_write) - (YAW+1)'(y_pop);
      if (state_q == ST_IDLE && hist_we) y_mem[hist_addr] <= hist_data;
      if (state_q != ST_IDLE && stop_req) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_ok) begin
            p_q      <= param_p;
            q_q      <= param_q;
            gain_q   <= param_gain;
            fb_q     <= '0;
            wr_q     <= YAW'(param_q);
            rd_q     <= YAW'(param_q);
            unread_q <= '0;
            state_q  <= ST_WAIT;
          end
          ST_WAIT: if (x_count >= (XAW+1)'(p_q) && y_space) begin
            k_q     <= '0;
            state_q <= ST_MAC;
          end
          ST_MAC: begin
            k_q <= k_q + 1'b1;
            if (k_q == terms - 1'b1) state_q <= ST_WRITE;
          end
          ST_WRITE: begin
            y_mem[wr_q] <= sat_res;
            wr_q    <= wr_q + 1'b1;
            fb_q    <= fb_q + 1'b1;
            state_q <= ST_WAIT;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_reject_bad_func_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && param_we && param_start && param_func != FUNC_IIR) |=> !busy);
  assert_window_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MAC |-> x_count >= (XAW+1)'(p_q));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WRITE |-> unread_q < (YAW+1)'(YDEPTH));
  assert_stop_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (param_we && !param_start) |=> !busy);
  assert_y_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready && !param_we && !hist_we) |=> (y_valid && $stable(y_data)));
endmodule

// File: tb/iir_seq_engine_bench.sv
module iir_seq_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic param_we = 0, param_start = 0;
  logic [3:0] param_func = 0, param_p = 0, param_q = 0;
  logic [2:0] param_gain = 0;
  logic coef_we = 0, hist_we = 0;
  logic [3:0] coef_addr = 0, hist_addr = 0;
  logic [15:0] coef_data = 0, hist_data = 0, x_data = 0;
  logic x_valid = 0, y_ready = 0;
  logic x_ready, y_valid, busy;
  logic [15:0] y_data;

  always #4 clk = ~clk;

  iir_seq_engine u_iir_seq_engine (
    .clk(clk), .rst_n(rst_n), .param_we(param_we), .param_func(param_func),
    .param_p(param_p), .param_q(param_q), .param_gain(param_gain),
    .param_start(param_start), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .hist_we(hist_we), .hist_addr(hist_addr),
    .hist_data(hist_data), .x_valid(x_valid), .x_ready(x_ready),
    .x_data(x_data), .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
    .busy(busy)
  );

  int total = 0, fails = 0;
  bit done = 0;
  longint cf[16];
  longint ym[16];
  longint xq[$];
  int mp = 1, mq = 0, mg = 0, mfb = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint model_next();
    longint acc = 0, r;
    for (int i = 0; i < mp; i++) acc += cf[i] * xq[i];
    for (int j = 0; j < mq; j++) acc += cf[mp + j] * ym[(mfb + j) % 16];
    r = acc <<< mg;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    ym[(mfb + mq) % 16] = r;
    mfb++;
    void'(xq.pop_front());
    return r;
  endfunction

  task automatic load_coef(int a, longint v);
    coef_we = 1; coef_addr = 4'(a); coef_data = 16'(v);
    tick();
    coef_we = 0;
    cf[a] = v;
  endtask

  task automatic load_hist(int a, longint v);
    hist_we = 1; hist_addr = 4'(a); hist_data = 16'(v);
    tick();
    hist_we = 0;
    ym[a] = v;
  endtask

  task automatic param_write(int f, int p, int q, int g, bit s);
    param_we = 1; param_func = 4'(f); param_p = 4'(p); param_q = 4'(q);
    param_gain = 3'(g); param_start = s;
    tick();
    param_we = 0;
  endtask

  task automatic start(int p, int q, int g);
    param_write(9, p, q, g, 1);
    mp = p; mq = q; mg = g; mfb = 0;
  endtask

  task automatic push(longint v);
    x_valid = 1; x_data = 16'(v);
    while (!x_ready) tick();
    tick();
    x_valid = 0;
    xq.push_back(v);
  endtask

  task automatic take(string req);
    int n = 0;
    longint e;
    while (!y_valid && n < 400) begin tick(); n++; end
    if (!y_valid) begin
      chk({req, " result timeout"}, 0, 1);
      return;
    end
    e = model_next();
    chk(req, longint'($signed(y_data)), e);
    y_ready = 1;
    tick();
    y_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 y_valid", y_valid, 0);
    chk("R1 x_ready", x_ready, 1);
  endtask

  task automatic t_reject();
    param_write(5, 2, 0, 0, 1);
    chk("R2 wrong function code", busy, 0);
    param_write(9, 0, 0, 0, 1);
    chk("R2 zero P", busy, 0);
    param_write(9, 9, 0, 0, 1);
    chk("R2 P above max", busy, 0);
    param_write(9, 2, 8, 0, 1);
    chk("R2 Q above max", busy, 0);
    chk("R2 no result", y_valid, 0);
  endtask

  task automatic t_full_output();
    int acc = 0;
    load_coef(0, 1);
    for (int i = 0; i < 16; i++) push(100 + i);
    chk("R10 ring full", x_ready, 0);
    start(1, 0, 0);
    repeat (120) tick();
    chk("R9 still running", busy, 1);
    for (int i = 0; i < 20; i++) begin
      if (!x_ready) break;
      push(200 + i);
      acc++;
    end
    chk("R9 no input consumed while output full", acc, 16);
    for (int i = 0; i < 32; i++) take("R9 ordered no-loss result");
    param_write(9, 0, 0, 0, 0);
  endtask

  task automatic t_fir_latency_stop();
    int cyc = 0;
    load_coef(0, 1); load_coef(1, 2); load_coef(2, 3);
    for (int i = 0; i < 5; i++) push(i * 7 - 9);
    start(3, 0, 0);
    while (!y_valid && cyc < 100) begin tick(); cyc++; end
    chk("R12 first result latency", cyc, 5);
    for (int i = 0; i < 3; i++) take("R3 R4 R7 feed-forward result");
    param_write(9, 0, 0, 0, 0);
    chk("R11 busy after stop", busy, 0);
    push(11); push(-5);
    repeat (30) tick();
    chk("R11 no result after stop", y_valid, 0);
  endtask

  task automatic t_iir_feedback();
    load_coef(0, 2); load_coef(1, -1); load_coef(2, 1); load_coef(3, -1);
    load_hist(0, 10); load_hist(1, -4);
    start(2, 2, 0);
    for (int i = 0; i < 3; i++) take("R5 R7 feedback from history");
    push(6); push(-3); push(8);
    for (int i = 0; i < 3; i++) take("R7 feedback from own results");
    param_write(9, 0, 0, 0, 0);
  endtask

  task automatic t_input_stall();
    for (int i = 0; i < 4; i++) load_coef(i, 1);
    start(4, 0, 0);
    repeat (30) tick();
    chk("R6 busy while starved", busy, 1);
    chk("R6 no result with 1 sample", y_valid, 0);
    push(40); push(50);
    repeat (30) tick();
    chk("R6 no result with 3 samples", y_valid, 0);
    push(60);
    take("R6 result once 4 samples present");
    param_write(9, 0, 0, 0, 0);
  endtask

  task automatic t_saturate();
    int n;
    load_coef(0, 300);
    push(200); push(-200); push(5);
    start(1, 0, 2);
    n = xq.size();
    for (int i = 0; i < n; i++) take("R8 gain shift and saturation");
    param_write(9, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin cf[i] = 0; ym[i] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_reject();
    t_full_output();
    t_fir_latency_stop();
    t_iir_feedback();
    t_input_stall();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule